// File: doc/BRIEF.md
# Unpacked Float to Single-Precision Packer

This block takes a floating value held in an unpacked working form and produces a 32-bit IEEE-754 single-precision word. The working form has a class code, a sign, a two's-complement unbiased exponent and a left-aligned significand whose top bit is the implied one. The significand is wider than the 24 bits a single keeps, so it also carries guard, round and further low bits, and a separate sticky input stands for anything already discarded upstream. An arithmetic pipeline places the block at its write-back end, where it turns its internal result into the architectural format.

On one pass the block adds the single-precision bias to the exponent. Values that land at or below the normal range are shifted further right into the subnormal range. The kept 24 bits are then rounded in one of four modes. A rounding carry moves the exponent up, either from a subnormal to the smallest normal or from a normal to the next binade. An exponent that reaches the reserved value becomes an overflow, and the mode and the sign then choose between infinity and the largest finite value. NaN, infinity and zero inputs bypass rounding. Every accepted input gives a registered result one clock later. The inexact indication belongs to that one result. Overflow and underflow collect in sticky flags until a synchronous clear.

Top module: `fpk_single_packer`

## Requirements
- R1: Class zero (in_cls=0) packs as the sign bit alone. Class infinity (in_cls=2) packs as the sign, exponent field 255 and fraction 0. Neither sets inexact or a flag, whatever in_sticky and rnd_mode are.
- R2: Class NaN (in_cls=3) packs as the sign and exponent field 255. The fraction is the 23 significand bits just below the implied one, with fraction bit 22 forced to 1. The input exponent has no effect, and no flag or inexact is set.
- R3: For class number (in_cls=1) with a normalized significand (top bit 1), the exponent field is in_exp+127 when that value is from 1 to 254. The fraction is the 23 significand bits below the implied one. An input with no discarded bits packs with inexact 0.
- R4: Mode 0 rounds to nearest. Below half of the last kept unit rounds down and above half rounds up. An exact half rounds to the even kept value.
- R5: Mode 1 truncates toward zero. Mode 2 rounds the magnitude up only for positive values and mode 3 only for negative values, when any discarded bit or in_sticky is set. Whenever anything is discarded, inexact is 1.
- R6: On the normal path, a rounding carry out of the 24 kept bits increments the exponent field and leaves a zero fraction.
- R7: If the exponent field would reach 255 after rounding, the result overflows and inexact is 1. Infinity is chosen in mode 0, in mode 2 for positive values and in mode 3 for negative values, and ovf_flag is then set. Otherwise the result is exponent field 254 with an all-ones fraction, and ovf_flag is not set.
- R8: When in_exp+127 is 0 or less, the significand, implied one included, is shifted right by 1-(in_exp+127) more places before rounding. The exponent field is then 0, and a shift past the whole significand leaves only sticky information.
- R9: A subnormal whose rounding carries into bit 23 packs as the smallest normal (exponent field 1, fraction 0), and does not set unf_flag.
- R10: A result that stays subnormal sets unf_flag if it is inexact, or if unf_enable is 1, even when it is exact.
- R11: ovf_flag and unf_flag are sticky. They hold until a cycle with flag_clr=1. In a cycle with both flag_clr and a new event, the new event wins and sets the flag.
- R12: A result appears on out_word and out_inexact in the cycle after in_valid, with out_valid 1 in that cycle only. With in_valid 0 the outputs hold. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present this cycle |
| in_cls | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | EXP_W (10) | Unbiased exponent, two's complement |
| in_mant | input | MANT_W (32) | Significand, implied one at the top bit |
| in_sticky | input | 1 | Some lower bits were already discarded |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| unf_enable | input | 1 | Flag underflow on exact subnormal results as well |
| flag_clr | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result registered this cycle |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Result differs from the exact input value |
| ovf_flag | output | 1 | Sticky overflow-to-infinity flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The value set walks the binade at 1.0 with discarded tails just below, exactly at and just above one half unit. This separates tie-to-even from plain round-half-up, and the sign-dependent directed modes from each other and from truncation. Overflow is tried both at the largest normal, where only a rounding carry overflows, and with an exponent already out of range, across every mode and sign, so infinity and the largest finite value are told apart. The subnormal cases run from the smallest normal down through the largest subnormal, the smallest subnormal, a value of exactly half of it and a value far below. These show the promotion to the smallest normal, the extra shift and its saturation, and underflow raised by inexactness as opposed to by the enable. Special classes with sticky or odd exponent inputs show that rounding and exponent play no part there, and directed sequences show flag retention, clearing, set-over-clear and output hold.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

   typedef enum logic [1:0] {
      FCLS_ZERO = 2'd0,
      FCLS_NUM  = 2'd1,
      FCLS_INF  = 2'd2,
      FCLS_NAN  = 2'd3
   } fcls_e;

   typedef enum logic [1:0] {
      RMD_NEAR_EVEN = 2'd0,
      RMD_TO_ZERO   = 2'd1,
      RMD_UP        = 2'd2,
      RMD_DOWN      = 2'd3
   } rmode_e;

   // single-precision geometry
   localparam int SGL_FRAC_W  = 23;
   localparam int SGL_EXP_W   = 8;
   localparam int SGL_KEEP_W  = SGL_FRAC_W + 1;
   localparam int SGL_BIAS    = 127;
   localparam int SGL_EXP_TOP = (1 << SGL_EXP_W) - 1;
   localparam int SGL_WORD_W  = 1 + SGL_EXP_W + SGL_FRAC_W;

endpackage

// File: rtl/fpk_rshift_sticky.sv
// Logarithmic right shifter that folds every bit pushed off the low end
// into a single lost-bits indication.
module fpk_rshift_sticky #(
   parameter int W    = 32,
   parameter int SH_W = $clog2(W + 1)
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] sh,
   output logic [W-1:0]    dout,
   output logic            lost
);

   if (W < 2) begin : g_bad_w
      $error("fpk_rshift_sticky: W must be at least 2");
   end

   logic [W-1:0] stage_d [SH_W+1];
   logic         stage_l [SH_W+1];

   assign stage_d[0] = din;
   assign stage_l[0] = 1'b0;

   for (genvar i = 0; i < SH_W; i++) begin : g_stage
      localparam int AMT = 1 << i;
      if (AMT >= W) begin : g_flush
         assign stage_d[i+1] = sh[i] ? '0 : stage_d[i];
         assign stage_l[i+1] = stage_l[i] | (sh[i] & (|stage_d[i]));
      end else begin : g_part
         assign stage_d[i+1] = sh[i] ? (stage_d[i] >> AMT) : stage_d[i];
         assign stage_l[i+1] = stage_l[i] | (sh[i] & (|stage_d[i][AMT-1:0]));
      end
   end

   assign dout = stage_d[SH_W];
   assign lost = stage_l[SH_W];

endmodule

// File: rtl/fpk_rounder.sv
// Rounds a kept field given guard, round and sticky, in one of four modes.
module fpk_rounder
   import fpk_pkg::*;
#(
   parameter int KW = SGL_KEEP_W
) (
   input  logic [KW-1:0] keep,
   input  logic          guard_b,
   input  logic          round_b,
   input  logic          sticky_b,
   input  logic          sign,
   input  logic [1:0]    mode,
   output logic [KW:0]   sum,
   output logic          inexact
);

   logic loss;
   logic bump;

   assign loss = guard_b | round_b | sticky_b;

   always_comb begin
      case (rmode_e'(mode))
         RMD_NEAR_EVEN: bump = guard_b & (round_b | sticky_b | keep[0]);
         RMD_TO_ZERO:   bump = 1'b0;
         RMD_UP:        bump = ~sign & loss;
         default:       bump = sign & loss;
      endcase
   end

   assign sum     = {1'b0, keep} + {{KW{1'b0}}, bump};
   assign inexact = loss;

endmodule

// File: rtl/fpk_ovf_policy.sv
// Chooses the overflow result: infinity or the largest finite magnitude.
module fpk_ovf_policy
   import fpk_pkg::*;
(
   input  logic                  sign,
   input  logic [1:0]            mode,
   output logic                  to_inf,
   output logic [SGL_WORD_W-1:0] word
);

   always_comb begin
      case (rmode_e'(mode))
         RMD_NEAR_EVEN: to_inf = 1'b1;
         RMD_TO_ZERO:   to_inf = 1'b0;
         RMD_UP:        to_inf = ~sign;
         default:       to_inf = sign;
      endcase
   end

   localparam logic [SGL_EXP_W-1:0] EXP_ALL = SGL_EXP_W'(SGL_EXP_TOP);
   localparam logic [SGL_EXP_W-1:0] EXP_MAX = SGL_EXP_W'(SGL_EXP_TOP - 1);

   assign word = to_inf ? {sign, EXP_ALL, {SGL_FRAC_W{1'b0}}}
                        : {sign, EXP_MAX, {SGL_FRAC_W{1'b1}}};

endmodule

// File: rtl/fpk_single_packer.sv
// Packs an unpacked float into a single-precision word, one result per
// accepted input, registered.
module fpk_single_packer
   import fpk_pkg::*;
#(
   parameter int EXP_W  = 10,
   parameter int MANT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_cls,
   input  logic              in_sign,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [MANT_W-1:0] in_mant,
   input  logic              in_sticky,
   input  logic [1:0]        rnd_mode,
   input  logic              unf_enable,
   input  logic              flag_clr,
   output logic              out_valid,
   output logic [31:0]       out_word,
   output logic              out_inexact,
   output logic              ovf_flag,
   output logic              unf_flag
);

   localparam int BE_W   = EXP_W + 2;
   localparam int SH_W   = $clog2(MANT_W + 1);
   localparam int LOW_W  = MANT_W - SGL_KEEP_W - 2;
   localparam int GRD_AT = MANT_W - SGL_KEEP_W - 1;

   if (MANT_W < SGL_KEEP_W + 2) begin : g_bad_mant
      $error("fpk_single_packer: MANT_W must hold 24 kept bits plus guard and round");
   end
   if (EXP_W < SGL_EXP_W + 1) begin : g_bad_exp
      $error("fpk_single_packer: EXP_W must cover the single exponent range");
   end
   if (MANT_W >= (1 << EXP_W)) begin : g_bad_ratio
      $error("fpk_single_packer: MANT_W too large for the shift saturation compare");
   end

   // biased exponent and subnormal detection
   logic signed [BE_W-1:0] bexp;
   logic signed [BE_W-1:0] dfull;
   logic                   is_sub;
   logic [SH_W-1:0]        sh;

   assign bexp   = $signed({{2{in_exp[EXP_W-1]}}, in_exp}) + $signed(BE_W'(SGL_BIAS));
   assign is_sub = bexp[BE_W-1] | (bexp == '0);
   assign dfull  = $signed(BE_W'(1)) - bexp;

   always_comb begin
      if (!is_sub)
         sh = '0;
      else if (dfull > $signed(BE_W'(MANT_W)))
         sh = SH_W'(MANT_W);
      else
         sh = dfull[SH_W-1:0];
   end

   // denormalizing shift
   logic [MANT_W-1:0] shifted;
   logic              shift_lost;

   fpk_rshift_sticky #(
      .W    (MANT_W),
      .SH_W (SH_W)
   ) u_shift (
      .din  (in_mant),
      .sh   (sh),
      .dout (shifted),
      .lost (shift_lost)
   );

   // split into kept field, guard, round and sticky
   logic [SGL_KEEP_W-1:0] keep;
   logic                  grd;
   logic                  rnd;
   logic                  low_or;
   logic                  stk;

   assign keep = shifted[MANT_W-1 -: SGL_KEEP_W];
   assign grd  = shifted[GRD_AT];
   assign rnd  = shifted[GRD_AT-1];

   if (LOW_W > 0) begin : g_low
      assign low_or = |shifted[LOW_W-1:0];
   end else begin : g_nolow
      assign low_or = 1'b0;
   end

   assign stk = low_or | shift_lost | in_sticky;

   // rounding
   logic [SGL_KEEP_W:0] sum;
   logic                rnd_inx;

   fpk_rounder #(
      .KW (SGL_KEEP_W)
   ) u_round (
      .keep     (keep),
      .guard_b  (grd),
      .round_b  (rnd),
      .sticky_b (stk),
      .sign     (in_sign),
      .mode     (rnd_mode),
      .sum      (sum),
      .inexact  (rnd_inx)
   );

   // overflow choice
   logic                  ovf_to_inf;
   logic [SGL_WORD_W-1:0] ovf_word;

   fpk_ovf_policy u_ovf (
      .sign   (in_sign),
      .mode   (rnd_mode),
      .to_inf (ovf_to_inf),
      .word   (ovf_word)
   );

   // exponent after a possible carry on the normal path
   logic signed [BE_W-1:0] exp_after;
   logic                   nrm_ovf;

   assign exp_after = bexp + $signed({{(BE_W-1){1'b0}}, sum[SGL_KEEP_W]});
   assign nrm_ovf   = exp_after >= $signed(BE_W'(SGL_EXP_TOP));

   localparam logic [SGL_EXP_W-1:0] EXP_ALL = SGL_EXP_W'(SGL_EXP_TOP);

   // result assembly
   logic [SGL_WORD_W-1:0] nxt_word;
   logic                  nxt_inx;
   logic                  nxt_ovf;
   logic                  nxt_unf;
   logic [SGL_FRAC_W-1:0] nan_frac;

   assign nan_frac = {1'b1, in_mant[MANT_W-3 -: SGL_FRAC_W-1]};

   always_comb begin
      nxt_word = '0;
      nxt_inx  = 1'b0;
      nxt_ovf  = 1'b0;
      nxt_unf  = 1'b0;
      case (fcls_e'(in_cls))
         FCLS_ZERO: begin
            nxt_word = {in_sign, {(SGL_WORD_W-1){1'b0}}};
         end
         FCLS_INF: begin
            nxt_word = {in_sign, EXP_ALL, {SGL_FRAC_W{1'b0}}};
         end
         FCLS_NAN: begin
            nxt_word = {in_sign, EXP_ALL, nan_frac};
         end
         default: begin
            nxt_inx = rnd_inx;
            if (is_sub) begin
               if (sum[SGL_KEEP_W-1]) begin
                  nxt_word = {in_sign, SGL_EXP_W'(1), {SGL_FRAC_W{1'b0}}};
               end else begin
                  nxt_word = {in_sign, {SGL_EXP_W{1'b0}}, sum[SGL_FRAC_W-1:0]};
                  nxt_unf  = rnd_inx | unf_enable;
               end
            end else if (nrm_ovf) begin
               nxt_word = ovf_word;
               nxt_inx  = 1'b1;
               nxt_ovf  = ovf_to_inf;
            end else begin
               nxt_word = {in_sign, exp_after[SGL_EXP_W-1:0], sum[SGL_FRAC_W-1:0]};
            end
         end
      endcase
   end

   // registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_word    <= '0;
         out_inexact <= 1'b0;
         ovf_flag    <= 1'b0;
         unf_flag    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word    <= nxt_word;
            out_inexact <= nxt_inx;
         end
         ovf_flag <= (ovf_flag & ~flag_clr) | (in_valid & nxt_ovf);
         unf_flag <= (unf_flag & ~flag_clr) | (in_valid & nxt_unf);
      end
   end

endmodule

// File: rtl/fpk_pack_sva.sv
module fpk_pack_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [1:0]  in_cls,
   input logic        flag_clr,
   input logic        out_valid,
   input logic [31:0] out_word,
   input logic        out_inexact,
   input logic        ovf_flag,
   input logic        unf_flag
);

   // R12
   a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r12_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r12_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word) && $stable(out_inexact));

   // R11
   a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !flag_clr |=> ovf_flag);
   a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unf_flag && !flag_clr |=> unf_flag);
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !in_valid |=> !ovf_flag && !unf_flag);

   // R1
   a_r1_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_cls == 2'd0 |=> out_word[30:0] == 31'd0 && !out_inexact);
   a_r1_inf: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_cls == 2'd2 |=> out_word[30:0] == 31'h7F80_0000 && !out_inexact);

   // R2
   a_r2_nan: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_cls == 2'd3 |=> out_word[30:22] == 9'h1FF && !out_inexact);

   // R7
   a_r7_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> out_word[30:0] == 31'h7F80_0000 && out_inexact);

   // R10
   a_r10_unf_is_sub: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unf_flag) |-> out_word[30:23] == 8'd0);

endmodule

bind fpk_single_packer fpk_pack_sva u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_cls      (in_cls),
   .flag_clr    (flag_clr),
   .out_valid   (out_valid),
   .out_word    (out_word),
   .out_inexact (out_inexact),
   .ovf_flag    (ovf_flag),
   .unf_flag    (unf_flag)
);

// File: tb/tb_fpk_single_packer.sv
`timescale 1ns/1ps
module tb_fpk_single_packer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_cls = '0;
   logic        in_sign = 1'b0;
   logic [9:0]  in_exp = '0;
   logic [31:0] in_mant = '0;
   logic        in_sticky = 1'b0;
   logic [1:0]  rnd_mode = '0;
   logic        unf_enable = 1'b0;
   logic        flag_clr = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_inexact;
   logic        ovf_flag;
   logic        unf_flag;

   always #2.5 clk = ~clk;

   fpk_single_packer dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
      .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
      .in_sticky(in_sticky), .rnd_mode(rnd_mode), .unf_enable(unf_enable),
      .flag_clr(flag_clr), .out_valid(out_valid), .out_word(out_word),
      .out_inexact(out_inexact), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [1:0]  cls;
      logic        sgn;
      logic [9:0]  ex;
      logic [31:0] mt;
      logic        stk;
      logic [1:0]  md;
      logic        ufe;
      logic [31:0] word;
      logic        inx;
      logic        ovf;
      logic        unf;
   } vec_t;

   function automatic vec_t mk(int rq, int cls, int sgn, int ex, logic [31:0] mt,
                               int stk, int md, int ufe, logic [31:0] w,
                               int inx, int ovf, int unf);
      vec_t v;
      v.req = 4'(rq);   v.cls = 2'(cls); v.sgn = 1'(sgn); v.ex = 10'(ex);
      v.mt  = mt;       v.stk = 1'(stk); v.md  = 2'(md);  v.ufe = 1'(ufe);
      v.word = w;       v.inx = 1'(inx); v.ovf = 1'(ovf); v.unf = 1'(unf);
      return v;
   endfunction

   localparam int NV = 41;
   // classes: 0 zero, 1 number, 2 inf, 3 NaN; modes: 0 NE, 1 TZ, 2 UP, 3 DN
   localparam vec_t VECS [NV] = '{
      mk(3, 1,0,   0, 32'h8000_0000,0,0,0, 32'h3F80_0000,0,0,0), // R3 1.0
      mk(3, 1,1,   0, 32'hC000_0000,0,0,0, 32'hBFC0_0000,0,0,0), // R3 -1.5
      mk(4, 1,0,   0, 32'h8000_0080,0,0,0, 32'h3F80_0000,1,0,0), // R4 tie even down
      mk(4, 1,0,   0, 32'h8000_0180,0,0,0, 32'h3F80_0002,1,0,0), // R4 tie odd up
      mk(4, 1,0,   0, 32'h8000_00C0,0,0,0, 32'h3F80_0001,1,0,0), // R4 above half
      mk(5, 1,0,   0, 32'h8000_0080,0,2,0, 32'h3F80_0001,1,0,0), // R5 up positive
      mk(5, 1,1,   0, 32'h8000_0080,0,2,0, 32'hBF80_0000,1,0,0), // R5 up negative
      mk(5, 1,1,   0, 32'h8000_0080,0,3,0, 32'hBF80_0001,1,0,0), // R5 down negative
      mk(5, 1,0,   0, 32'h8000_00FF,0,1,0, 32'h3F80_0000,1,0,0), // R5 toward zero
      mk(5, 1,0,   0, 32'h8000_0000,1,2,0, 32'h3F80_0001,1,0,0), // R5 sticky only, up
      mk(5, 1,0,   0, 32'h8000_0000,1,0,0, 32'h3F80_0000,1,0,0), // R5 sticky only, nearest
      mk(6, 1,0,   0, 32'hFFFF_FFFF,0,0,0, 32'h4000_0000,1,0,0), // R6 carry to 2.0
      mk(3, 1,0, 127, 32'hFFFF_FF00,0,0,0, 32'h7F7F_FFFF,0,0,0), // R3 largest normal
      mk(7, 1,0, 127, 32'hFFFF_FF80,0,0,0, 32'h7F80_0000,1,1,0), // R7 carry overflow
      mk(5, 1,0, 127, 32'hFFFF_FF80,0,1,0, 32'h7F7F_FFFF,1,0,0), // R5 truncated, no ovf
      mk(7, 1,1, 127, 32'hFFFF_FF80,0,3,0, 32'hFF80_0000,1,1,0), // R7 down negative
      mk(7, 1,0, 128, 32'h8000_0000,0,1,0, 32'h7F7F_FFFF,1,0,0), // R7 tz max finite
      mk(7, 1,1, 128, 32'h8000_0000,0,2,0, 32'hFF7F_FFFF,1,0,0), // R7 up negative
      mk(7, 1,0, 128, 32'h8000_0000,0,2,0, 32'h7F80_0000,1,1,0), // R7 up positive
      mk(7, 1,1, 128, 32'h8000_0000,0,3,0, 32'hFF80_0000,1,1,0), // R7 down negative
      mk(7, 1,0, 128, 32'h8000_0000,0,3,0, 32'h7F7F_FFFF,1,0,0), // R7 down positive
      mk(7, 1,1, 128, 32'h8000_0000,0,0,0, 32'hFF80_0000,1,1,0), // R7 nearest
      mk(3, 1,0,-126, 32'h8000_0000,0,0,0, 32'h0080_0000,0,0,0), // R3 smallest normal
      mk(8, 1,0,-127, 32'h8000_0000,0,0,0, 32'h0040_0000,0,0,0), // R8 exact subnormal
      mk(10,1,0,-127, 32'h8000_0000,0,0,1, 32'h0040_0000,0,0,1), // R10 enable on exact
      mk(9, 1,0,-127, 32'hFFFF_FFFF,0,0,0, 32'h0080_0000,1,0,0), // R9 promote
      mk(10,1,0,-127, 32'hFFFF_FFFF,0,1,0, 32'h007F_FFFF,1,0,1), // R10 stays, inexact
      mk(8, 1,0,-149, 32'h8000_0000,0,0,0, 32'h0000_0001,0,0,0), // R8 smallest subnormal
      mk(8, 1,0,-150, 32'h8000_0000,0,0,0, 32'h0000_0000,1,0,1), // R8 half of it, even
      mk(8, 1,0,-150, 32'h8000_0000,0,2,0, 32'h0000_0001,1,0,1), // R8 half of it, up
      mk(8, 1,0,-400, 32'h8000_0000,0,2,0, 32'h0000_0001,1,0,1), // R8 saturated, up
      mk(8, 1,1,-400, 32'h8000_0000,0,2,0, 32'h8000_0000,1,0,1), // R8 saturated, neg
      mk(2, 3,0,   0, 32'h8000_0000,0,0,0, 32'h7FC0_0000,0,0,0), // R2 quiet bit forced
      mk(2, 3,1,   5, 32'hA000_0000,0,0,0, 32'hFFE0_0000,0,0,0), // R2 payload kept
      mk(2, 3,0,   0, 32'hFFFF_FFFF,1,2,0, 32'h7FFF_FFFF,0,0,0), // R2 full payload
      mk(1, 2,1,   0, 32'h0000_0000,0,0,0, 32'hFF80_0000,0,0,0), // R1 -inf
      mk(1, 2,0, 200, 32'hFFFF_FFFF,1,2,0, 32'h7F80_0000,0,0,0), // R1 +inf
      mk(1, 0,1,   0, 32'h0000_0000,0,0,0, 32'h8000_0000,0,0,0), // R1 -zero
      mk(1, 0,0,   0, 32'h0000_0000,1,2,1, 32'h0000_0000,0,0,0), // R1 zero, sticky
      mk(8, 1,0,-127, 32'hFFFF_FE00,0,0,0, 32'h007F_FFFF,0,0,0), // R8 largest subnormal
      mk(10,1,0,-127, 32'hFFFF_FE00,0,0,1, 32'h007F_FFFF,0,0,1)  // R10 largest sub, enable
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   // drives one vector for a single cycle; returns at the following negedge
   task automatic drive(vec_t v, bit clr);
      @(negedge clk);
      in_valid = 1'b1; in_cls = v.cls; in_sign = v.sgn; in_exp = v.ex;
      in_mant = v.mt; in_sticky = v.stk; rnd_mode = v.md; unf_enable = v.ufe;
      flag_clr = clr;
      @(negedge clk);
      in_valid = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      // R12 reset state
      repeat (3) @(negedge clk);
      chk("R12 reset out_valid", 32'(out_valid), 32'd0);
      chk("R12 reset out_word", out_word, 32'd0);
      chk("R12 reset inexact", 32'(out_inexact), 32'd0);
      chk("R12 reset ovf_flag", 32'(ovf_flag), 32'd0);
      chk("R12 reset unf_flag", 32'(unf_flag), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i], 1'b1);
         chk($sformatf("R%0d vec %0d word", VECS[i].req, i), out_word, VECS[i].word);
         chk($sformatf("R%0d vec %0d inexact", VECS[i].req, i), 32'(out_inexact), 32'(VECS[i].inx));
         chk($sformatf("R%0d vec %0d ovf", VECS[i].req, i), 32'(ovf_flag), 32'(VECS[i].ovf));
         chk($sformatf("R%0d vec %0d unf", VECS[i].req, i), 32'(unf_flag), 32'(VECS[i].unf));
         chk($sformatf("R12 vec %0d out_valid", i), 32'(out_valid), 32'd1);
      end

      // R12 valid lasts one cycle, word holds
      @(negedge clk);
      chk("R12 valid drops", 32'(out_valid), 32'd0);
      chk("R12 word holds", out_word, VECS[NV-1].word);

      // R11 overflow flag survives a later clean result
      drive(VECS[18], 1'b1);
      chk("R11 ovf set", 32'(ovf_flag), 32'd1);
      drive(VECS[0], 1'b0);
      chk("R11 ovf retained", 32'(ovf_flag), 32'd1);
      chk("R11 new word", out_word, 32'h3F80_0000);

      // R11 clear alone; R12 word unaffected
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk("R11 ovf cleared", 32'(ovf_flag), 32'd0);
      chk("R12 word held over clear", out_word, 32'h3F80_0000);

      // R11 set wins over clear in the same cycle, other flag clears
      drive(VECS[26], 1'b1);
      chk("R11 unf set", 32'(unf_flag), 32'd1);
      drive(VECS[13], 1'b1);
      chk("R11 ovf set with clear", 32'(ovf_flag), 32'd1);
      chk("R11 unf cleared", 32'(unf_flag), 32'd0);
      drive(VECS[26], 1'b0);
      chk("R11 both held", 32'({ovf_flag, unf_flag}), 32'd3);

      // R12 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12 reset again word", out_word, 32'd0);
      chk("R12 reset again flags", 32'({ovf_flag, unf_flag}), 32'd0);
      rst_n = 1'b1;

      done = 1'b1;
      finish_run();
   end

endmodule